// File: doc/BRIEF.md
# Multi-mode PWM time base

This block is the shared time reference for a group of PWM waveform generators. A 16-bit counter steps once for every `prescale+1` input clocks. The counter can count upward and wrap, count downward and reload, or rise to the period and fall back to zero. Generators downstream compare the count with their own thresholds. They use the one-clock zero and period strobes, and the tag that tells which way the counter was moving, to decide when to change their outputs.

Configuration arrives as static, register-style levels: prescale, period, a 2-bit counting mode (mode 0 holds the counter still) and a 2-bit run control. The counter runs only while the run control equals 2. A phase reload is requested by inverting a single sync bit. Each inversion loads a 16-bit phase and a direction into the counter on the next clock, whatever the mode is.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (increasing), all three strobe outputs are 0, and the prescale divider is cleared.
- R2: While running, the count changes exactly once every `prescale+1` clocks, where `prescale` is the 8-bit `cfg_prescale` input.
- R3: With mode 1 (up), the count steps 0,1,…,period, then returns to 0, so one cycle is period+1 steps. The direction output reads 0.
- R4: With mode 2 (down), the count steps period,…,1,0, then reloads the period, so one cycle is period+1 steps. The direction output reads 1.
- R5: With mode 3 (up-down), the count rises from 0 to the period and falls back to 0, so one cycle is 2×period steps. The direction output becomes 1 in the clock where the count reaches the period, and becomes 0 in the clock where it reaches 0.
- R6: With mode 0, the count and the direction hold their values.
- R7: The counter advances only while `cfg_run` equals 2. Any other run value holds the count and the direction.
- R8: When `sw_sync_tog` differs from its value in the previous clock, the next clock loads `sync_phase` into the count and `sync_down` into the direction (1 = decreasing). The prescale divider restarts. This works in every mode, and a sync takes priority over a step.
- R9: `evt_zero` is high for exactly one clock: the first clock in which a step has made the count 0. `evt_dir` is then 1 only if that step decreased the count.
- R10: `evt_period` is high for exactly one clock: the first clock in which a step has made the count equal the period. `evt_dir` is then 1 only if that step decreased the count. In down mode, a reload to the period counts as a decreasing step.
- R11: A new period or prescale value takes effect at the next step. In up mode, a count at or above the period steps to 0.
- R12: In up-down mode with period 0, the count stays at 0 and raises both strobes at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_prescale | input | 8 | Divider: one step per prescale+1 clocks |
| cfg_period | input | 16 | Period value |
| cfg_mode | input | 2 | 0 hold, 1 up, 2 down, 3 up-down |
| cfg_run | input | 2 | Run control; 2 = run continuously |
| sw_sync_tog | input | 1 | Software sync: each inversion requests a phase load |
| sync_phase | input | 16 | Value loaded into the count on sync |
| sync_down | input | 1 | Direction loaded on sync (1 = decreasing) |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | Current direction (1 = decreasing) |
| evt_zero | output | 1 | One-clock strobe when a step reaches 0 |
| evt_period | output | 1 | One-clock strobe when a step reaches the period |
| evt_dir | output | 1 | Direction of the step that raised a strobe |

## Verification
The bench measures the distance between strobes and compares it with the formulas for each mode and prescale. A divider that is off by one, or an up-down turnaround that repeats the peak, changes that distance. It changes the period below a running count and expects an immediate wrap; a design using an equality-only compare would instead count on toward 65535. It issues syncs while the block is frozen and while it is running, and checks that the phase and direction load and that the divider restarts. It drives period 0 in up-down mode, where a naive turnaround would underflow. Random configuration sequences are then compared clock by clock against a reference model.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD   = 2'd0,
      MODE_UP     = 2'd1,
      MODE_DOWN   = 2'd2,
      MODE_UPDOWN = 2'd3
   } tb_mode_e;

   localparam logic [1:0] RUN_FREE = 2'd2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clear,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] acc;
   logic             at_lim;

   // >= so that lowering the limit below the accumulator still fires
   assign at_lim = (acc >= limit);
   assign tick   = en && !clear && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (clear)   acc <= '0;
      else if (en)      acc <= at_lim ? '0 : acc + 1'b1;
   end
endmodule

// File: rtl/pwm_sync_detect.sv
module pwm_sync_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic tog,
   output logic req
);
   logic last_q;

   assign req = tog ^ last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= tog;
   end
endmodule

// File: rtl/pwm_step.sv
module pwm_step
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  tb_mode_e         mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             dir,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] nxt,
   output logic             ndir,
   output logic             tag_down
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] inc, dec;
   assign inc = cnt + ONE;
   assign dec = cnt - ONE;

   always_comb begin
      nxt      = cnt;
      ndir     = dir;
      tag_down = 1'b0;
      unique case (mode)
         MODE_UP: begin
            nxt  = (cnt >= period) ? '0 : inc;
            ndir = 1'b0;
         end
         MODE_DOWN: begin
            nxt      = (cnt == '0) ? period : dec;
            ndir     = 1'b1;
            tag_down = 1'b1;
         end
         MODE_UPDOWN: begin
            if (period == '0) begin
               nxt  = '0;
               ndir = 1'b0;
            end else if (!dir) begin
               if (cnt >= period) begin
                  nxt      = dec;
                  ndir     = (dec != '0);
                  tag_down = 1'b1;
               end else begin
                  nxt  = inc;
                  ndir = (inc >= period);
               end
            end else begin
               if (cnt == '0) begin
                  nxt  = ONE;
                  ndir = (ONE >= period);
               end else begin
                  nxt      = dec;
                  ndir     = (dec != '0);
                  tag_down = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] cfg_prescale,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_run,
   input  logic             sw_sync_tog,
   input  logic [CNT_W-1:0] sync_phase,
   input  logic             sync_down,
   output logic [CNT_W-1:0] count_o,
   output logic             dir_down_o,
   output logic             evt_zero,
   output logic             evt_period,
   output logic             evt_dir
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pwm_timebase: CNT_W must lie in 2..32");
      end
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre_w
         $error("pwm_timebase: PRE_W must lie in 1..16");
      end
   endgenerate

   tb_mode_e         mode;
   logic             active, tick, sync_req;
   logic [CNT_W-1:0] cnt_q, nxt;
   logic             dir_q, ndir, tag_down;
   logic             ez_q, ep_q, ed_q;

   assign mode   = tb_mode_e'(cfg_mode);
   assign active = (mode != MODE_HOLD) && (cfg_run == RUN_FREE);

   pwm_sync_detect u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tog   (sw_sync_tog),
      .req   (sync_req)
   );

   pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active),
      .clear (sync_req),
      .limit (cfg_prescale),
      .tick  (tick)
   );

   pwm_step #(.CNT_W(CNT_W)) u_step (
      .mode     (mode),
      .cnt      (cnt_q),
      .dir      (dir_q),
      .period   (cfg_period),
      .nxt      (nxt),
      .ndir     (ndir),
      .tag_down (tag_down)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
         ez_q  <= 1'b0;
         ep_q  <= 1'b0;
         ed_q  <= 1'b0;
      end else if (sync_req) begin
         cnt_q <= sync_phase;
         dir_q <= sync_down;
         ez_q  <= 1'b0;
         ep_q  <= 1'b0;
         ed_q  <= 1'b0;
      end else if (tick) begin
         cnt_q <= nxt;
         dir_q <= ndir;
         ez_q  <= (nxt == '0);
         ep_q  <= (nxt == cfg_period);
         ed_q  <= tag_down && ((nxt == '0) || (nxt == cfg_period));
      end else begin
         ez_q  <= 1'b0;
         ep_q  <= 1'b0;
         ed_q  <= 1'b0;
      end
   end

   assign count_o    = cnt_q;
   assign dir_down_o = dir_q;
   assign evt_zero   = ez_q;
   assign evt_period = ep_q;
   assign evt_dir    = ed_q;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic [1:0]       cfg_run,
   input logic [CNT_W-1:0] cfg_period,
   input logic [CNT_W-1:0] sync_phase,
   input logic             sync_down,
   input logic             sync_req,
   input logic             tick,
   input logic [CNT_W-1:0] count_o,
   input logic             dir_down_o,
   input logic             evt_zero,
   input logic             evt_period
);
   a_r8_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> (count_o == $past(sync_phase)) && (dir_down_o == $past(sync_down)));

   a_r6_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_req && !tick) |=> $stable(count_o) && $stable(dir_down_o));

   a_r7_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == MODE_HOLD || cfg_run != RUN_FREE) |-> !tick);

   a_r9_zero_strobe_value: assert property (@(posedge clk) disable iff (!rst_n)
      evt_zero |-> (count_o == '0));

   a_r10_period_strobe_value: assert property (@(posedge clk) disable iff (!rst_n)
      evt_period |-> (count_o == $past(cfg_period)));

   a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_req && cfg_mode == MODE_UP && count_o < cfg_period)
      |=> (count_o == CNT_W'($past(count_o) + 1'b1)) && !dir_down_o);

   a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_req && cfg_mode == MODE_DOWN && count_o != '0)
      |=> (count_o == CNT_W'($past(count_o) - 1'b1)) && dir_down_o);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode   (cfg_mode),
   .cfg_run    (cfg_run),
   .cfg_period (cfg_period),
   .sync_phase (sync_phase),
   .sync_down  (sync_down),
   .sync_req   (sync_req),
   .tick       (tick),
   .count_o    (count_o),
   .dir_down_o (dir_down_o),
   .evt_zero   (evt_zero),
   .evt_period (evt_period)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_prescale = '0;
   logic [15:0] cfg_period = '0;
   logic [1:0]  cfg_mode = '0;
   logic [1:0]  cfg_run = '0;
   logic        sw_sync_tog = 1'b0;
   logic [15:0] sync_phase = '0;
   logic        sync_down = 1'b0;
   logic [15:0] count_o;
   logic        dir_down_o, evt_zero, evt_period, evt_dir;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pwm_timebase dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [15:0] m_cnt;
   logic        m_dir, m_last, m_ez, m_ep, m_ed;
   logic [7:0]  m_pre;

   function automatic logic [17:0] ref_step(input logic [1:0] md, input logic [15:0] c,
                                            input logic d, input logic [15:0] p);
      logic [15:0] n; logic nd; logic tg;
      n = c; nd = d; tg = 1'b0;
      if (md == 2'd1) begin
         nd = 1'b0;
         n  = (c < p) ? c + 16'd1 : 16'd0;
      end else if (md == 2'd2) begin
         nd = 1'b1; tg = 1'b1;
         n  = (c != 0) ? c - 16'd1 : p;
      end else if (md == 2'd3) begin
         if (p == 0) begin n = 0; nd = 1'b0; end
         else begin
            // go down when heading down and above 0, or when at/above the peak
            if ((d && c != 0) || (!d && c >= p)) begin n = c - 16'd1; tg = 1'b1; nd = (n != 0); end
            else begin n = c + 16'd1; nd = (n >= p); end
         end
      end
      return {tg, nd, n};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_dir <= 0; m_last <= 0; m_ez <= 0; m_ep <= 0; m_ed <= 0; m_pre <= 0;
      end else begin
         logic sreq, run, stp;
         logic [17:0] r;
         sreq = (sw_sync_tog != m_last);
         run  = (cfg_mode != 0) && (cfg_run == 2'd2);
         stp  = run && !sreq && (m_pre >= cfg_prescale);
         m_last <= sw_sync_tog;
         if (sreq) m_pre <= 0;
         else if (run) m_pre <= (m_pre >= cfg_prescale) ? 8'd0 : m_pre + 8'd1;
         r = ref_step(cfg_mode, m_cnt, m_dir, cfg_period);
         if (sreq) begin
            m_cnt <= sync_phase; m_dir <= sync_down; m_ez <= 0; m_ep <= 0; m_ed <= 0;
         end else if (stp) begin
            m_cnt <= r[15:0]; m_dir <= r[16];
            m_ez  <= (r[15:0] == 0);
            m_ep  <= (r[15:0] == cfg_period);
            m_ed  <= r[17] && ((r[15:0] == 0) || (r[15:0] == cfg_period));
         end else begin
            m_ez <= 0; m_ep <= 0; m_ed <= 0;
         end
      end
   end

   bit cmp_en = 0;
   always @(negedge clk) if (cmp_en) begin
      chk("R2 R3 R4 R5 model count", count_o, m_cnt);
      chk("R5 R6 R8 model dir", dir_down_o, m_dir);
      chk("R9 model evt_zero", evt_zero, m_ez);
      chk("R10 model evt_period", evt_period, m_ep);
      chk("R9 R10 model evt_dir", evt_dir, m_ed);
   end

   // ---------------- helpers ----------------
   function automatic int len_linear(input int p, input int k); return (p + 1) * (k + 1); endfunction
   function automatic int len_updown(input int p, input int k); return 2 * p * (k + 1); endfunction

   task automatic gap(input bit use_zero, output int n);
      int guard = 0;
      do begin @(negedge clk); guard++; end
      while (!(use_zero ? evt_zero : evt_period) && guard < 5000);
      n = 0;
      do begin @(negedge clk); n++; end
      while (!(use_zero ? evt_zero : evt_period) && n < 5000);
   endtask

   task automatic do_sync(input logic [15:0] ph, input logic dn);
      sync_phase = ph; sync_down = dn; sw_sync_tog = ~sw_sync_tog;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      logic [15:0] held;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 count", count_o, 0);
      chk("R1 dir", dir_down_o, 0);
      chk("R1 evt_zero", evt_zero, 0);
      chk("R1 evt_period", evt_period, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1;

      // R3 up mode, prescale 0 then 2 (R2)
      cfg_period = 4; cfg_prescale = 0; cfg_mode = 1; cfg_run = 2;
      gap(1'b1, n); chk("R3 up cycle length", n, len_linear(4, 0));
      chk("R3 up dir", dir_down_o, 0);
      chk("R9 up zero tag", evt_dir, 0);
      cfg_prescale = 2;
      gap(1'b1, n); gap(1'b1, n); chk("R2 prescaled up length", n, len_linear(4, 2));

      // R4 down mode
      cfg_mode = 2; cfg_prescale = 1;
      gap(1'b0, n); gap(1'b0, n); chk("R4 down cycle length", n, len_linear(4, 1));
      chk("R4 down dir", dir_down_o, 1);
      chk("R10 reload tag", evt_dir, 1);

      // R5 up-down mode
      cfg_mode = 3; cfg_prescale = 0; cfg_period = 5;
      do_sync(0, 0);
      gap(1'b0, n);
      chk("R5 dir flips at peak", dir_down_o, 1);
      chk("R10 peak tag rising", evt_dir, 0);
      gap(1'b1, n);
      chk("R5 dir flips at zero", dir_down_o, 0);
      chk("R9 zero tag falling", evt_dir, 1);
      gap(1'b1, n); chk("R5 up-down cycle length", n, len_updown(5, 0));

      // R6 freeze
      cfg_mode = 0; @(negedge clk); held = count_o;
      repeat (20) @(negedge clk);
      chk("R6 frozen count", count_o, held);
      // R7 run control other than 2
      cfg_mode = 1; cfg_run = 1; @(negedge clk); held = count_o;
      repeat (20) @(negedge clk);
      chk("R7 stopped count", count_o, held);
      chk("R7 no strobe", evt_zero | evt_period, 0);

      // R8 sync while stopped
      do_sync(16'd123, 1'b1);
      chk("R8 phase loaded", count_o, 123);
      chk("R8 dir loaded", dir_down_o, 1);
      cfg_run = 2; cfg_mode = 2; cfg_prescale = 3; cfg_period = 500;
      do_sync(16'd50, 1'b1);
      repeat (4) @(negedge clk);
      chk("R8 divider restarted", count_o, 49);

      // R11 period lowered below a running up count
      cfg_mode = 1; cfg_prescale = 0; cfg_period = 200;
      do_sync(16'd10, 1'b0);
      cfg_period = 3; @(negedge clk);
      chk("R11 wrap above period", count_o, 0);
      chk("R11 zero strobe", evt_zero, 1);

      // R12 up-down with period 0
      cfg_mode = 3; cfg_period = 0;
      do_sync(16'd0, 1'b0);
      repeat (5) @(negedge clk);
      chk("R12 stays zero", count_o, 0);
      chk("R12 zero strobe", evt_zero, 1);
      chk("R12 period strobe", evt_period, 1);

      // random phase, checked against the model each clock
      for (int i = 0; i < 80; i++) begin
         cfg_mode     = 2'($urandom_range(0, 3));
         cfg_run      = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
         cfg_prescale = 8'($urandom_range(0, 3));
         cfg_period   = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, 12));
         if ($urandom_range(0, 2) == 0)
            do_sync(16'($urandom_range(0, 20)), 1'($urandom_range(0, 1)));
         repeat (40) @(negedge clk);
      end
      finish_run();
   end
endmodule